// File: doc/BRIEF.md
# Multiplexed Bus Address Latch Decoder

This block sits on the peripheral side of a 32-bit bus that carries address and data on the same wires. During the address phase, an active-low strobe marks that the wires hold an address word. The block registers three things from that word: the byte address, a two-bit bank number and a three-bit transfer-size code. It then turns them into four active-low chip selects, one per bank, and four byte-lane enables. The selects and enables stay in force through the data phase that follows.

The lane enables follow big-endian numbering. Lane 3 is bits 31..24 and lane 0 is bits 7..0. A byte at offset 0 therefore uses lane 3. If the size code is not one of the three legal codes, or the low address bits are not aligned for the size, the block raises an invalid flag and asserts no chip select and no lane. When the bus master acknowledges the cycle, the selects and enables drop on the next clock edge.

Everything is sampled on the rising clock edge, and every output is a register. While the strobe is low the capture registers reload on every edge, so they behave as a clocked transparent latch. When the strobe goes high they hold.

Top module: `mux_addr_latch`

## Requirements
- R1: On a clock edge with `rst` high, the following values appear: `addr_q`=0, `bank_q`=0, `size_q`=0, `cs_n`=4'b1111, `lane_en`=4'b0000 and `bad_xfer`=0.
- R2: On every edge where `strobe_n` is low, the capture registers load `addr_q`=`ad_in[24:0]`, `bank_q`=`ad_in[26:25]` and `size_q`=`ad_in[30:28]`. Consecutive low edges each reload them.
- R3: On an edge where `strobe_n` is high, `addr_q`, `bank_q` and `size_q` keep their values.
- R4: `ad_in[31]` and `ad_in[27]` have no effect on any output.
- R5: For a legal, aligned transfer, `cs_n[k]` is 0 for the captured bank k and all other chip selects are 1.
- R6: Size code 3'b001 (1 byte) enables a single lane. Offsets `ad_in[1:0]` 00, 01, 10 and 11 give `lane_en` 1000, 0100, 0010 and 0001.
- R7: Size code 3'b010 (2 bytes) gives `lane_en`=1100 at offset 00 and 0011 at offset 10.
- R8: Size code 3'b100 (4 bytes) at offset 00 gives `lane_en`=1111.
- R9: Any size code other than 001, 010 or 100 sets `bad_xfer`=1 and forces `cs_n`=1111 and `lane_en`=0000.
- R10: A misaligned offset gives the same result as R9. A misaligned offset is an odd offset with size 010, or a nonzero offset with size 100.
- R11: On an edge where `strobe_n` is high and `ack` is high, the block sets `cs_n`=1111, `lane_en`=0000 and `bad_xfer`=0. The captured address fields are not changed.
- R12: On an edge where `strobe_n` is low and `ack` is high at the same time, the capture of R2 takes priority and `ack` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_n | input | 1 | Address-phase strobe, active low |
| ad_in | input | 32 | Multiplexed address/data bus as seen by the block |
| ack | input | 1 | Cycle acknowledge; ends the data phase |
| addr_q | output | 25 | Captured byte address |
| bank_q | output | 2 | Captured bank number |
| size_q | output | 3 | Captured transfer-size code |
| cs_n | output | 4 | Per-bank chip selects, active low |
| lane_en | output | 4 | Byte-lane enables, bit 3 = bits 31..24 |
| bad_xfer | output | 1 | Illegal size code or misaligned offset |

## Verification
The decode is tried on every combination of bank, size code and offset. This sweep separates the three legal sizes from the five illegal codes, and aligned offsets from misaligned ones. It also confirms that only the selected bank's chip select drops.

Some patterns hold the strobe low across several edges, and others change the bus while the strobe is high. These show the difference between reloading and holding. Words with bits 31 and 27 set are compared against the same words with those bits clear, which shows that the two ignored bits have no effect. Acknowledges are applied both alone and together with a low strobe; this tells clearing apart from the capture-first priority.

// File: rtl/mal_pkg.sv
package mal_pkg;
  // Legal transfer-size codes carried in the address word
  localparam logic [2:0] SZ_ONE  = 3'b001;
  localparam logic [2:0] SZ_TWO  = 3'b010;
  localparam logic [2:0] SZ_FOUR = 3'b100;

  typedef struct packed {
    logic [2:0] size;
    logic [1:0] bank;
  } side_fields_t;
endpackage

// File: rtl/mal_field_capture.sv
module mal_field_capture #(
  parameter int AD_W     = 32,
  parameter int ADDR_W   = 25,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 25,
  parameter int SIZE_W   = 3,
  parameter int SIZE_LSB = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [AD_W-1:0]   ad,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [SIZE_W-1:0] size_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      bank_q <= '0;
      size_q <= '0;
    end else if (load) begin
      addr_q <= ad[ADDR_W-1:0];
      bank_q <= ad[BANK_LSB +: BANK_W];
      size_q <= ad[SIZE_LSB +: SIZE_W];
    end
  end

  // R3
  fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(addr_q) && $stable(bank_q) && $stable(size_q)));
endmodule

// File: rtl/mal_lane_decode.sv
module mal_lane_decode
  import mal_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int SIZE_W = 3,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [OFF_W-1:0]  off,
  output logic [LANES-1:0]  lane_en,
  output logic              invalid
);
  logic is_one, is_two, is_four;

  assign is_one  = (size == SZ_ONE);
  assign is_two  = (size == SZ_TWO);
  assign is_four = (size == SZ_FOUR);

  // Big-endian lanes: lane LANES-1 carries offset 0
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int K = LANES - 1 - i;
    logic hit_one, hit_two, hit_four;
    assign hit_one  = is_one  && (off == OFF_W'(K));
    assign hit_two  = is_two  && !off[0] && (off == OFF_W'(K & ~1));
    assign hit_four = is_four && (off == '0);
    assign lane_en[i] = hit_one | hit_two | hit_four;
  end

  assign invalid = !(is_one || is_two || is_four)
                 || (is_two && off[0])
                 || (is_four && (off != '0));
endmodule

// File: rtl/mal_bank_decode.sv
module mal_bank_decode #(
  parameter int BANK_W = 2,
  localparam int NB    = 1 << BANK_W
) (
  input  logic [BANK_W-1:0] bank,
  input  logic              enable,
  output logic [NB-1:0]     sel_n
);
  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign sel_n[b] = !(enable && (bank == BANK_W'(b)));
  end
endmodule

// File: rtl/mux_addr_latch.sv
module mux_addr_latch #(
  parameter int AD_W     = 32,
  parameter int ADDR_W   = 25,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 25,
  parameter int SIZE_W   = 3,
  parameter int SIZE_LSB = 28,
  parameter int LANES    = 4,
  localparam int NB      = 1 << BANK_W,
  localparam int OFF_W   = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n,
  input  logic [AD_W-1:0]   ad_in,
  input  logic              ack,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [SIZE_W-1:0] size_q,
  output logic [NB-1:0]     cs_n,
  output logic [LANES-1:0]  lane_en,
  output logic              bad_xfer
);
  logic             load;
  logic [LANES-1:0] lane_nxt;
  logic             inv_nxt;
  logic [NB-1:0]    cs_nxt;

  assign load = !strobe_n;

  mal_field_capture #(
    .AD_W(AD_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB),
    .SIZE_W(SIZE_W), .SIZE_LSB(SIZE_LSB)
  ) cap_i (
    .clk(clk), .rst(rst), .load(load), .ad(ad_in),
    .addr_q(addr_q), .bank_q(bank_q), .size_q(size_q)
  );

  mal_lane_decode #(.LANES(LANES), .SIZE_W(SIZE_W)) lane_i (
    .size(ad_in[SIZE_LSB +: SIZE_W]), .off(ad_in[OFF_W-1:0]),
    .lane_en(lane_nxt), .invalid(inv_nxt)
  );

  mal_bank_decode #(.BANK_W(BANK_W)) bank_i (
    .bank(ad_in[BANK_LSB +: BANK_W]), .enable(!inv_nxt), .sel_n(cs_nxt)
  );

  // Capture wins over acknowledge; acknowledge clears selects
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n     <= '1;
      lane_en  <= '0;
      bad_xfer <= 1'b0;
    end else if (load) begin
      cs_n     <= cs_nxt;
      lane_en  <= lane_nxt;
      bad_xfer <= inv_nxt;
    end else if (ack) begin
      cs_n     <= '1;
      lane_en  <= '0;
      bad_xfer <= 1'b0;
    end
  end

  // R5
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  // R9
  bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bad_xfer |-> (cs_n == '1 && lane_en == '0));

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_n && ack) |=> (cs_n == '1 && lane_en == '0 && !bad_xfer));

  // R5
  lanes_need_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_en != '0) |-> ($countones(~cs_n) == 1));
endmodule

// File: tb/mux_addr_latch_tb_top.sv
module mux_addr_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe_n = 1'b1;
  logic [31:0] ad_in = '0;
  logic        ack = 1'b0;
  logic [24:0] addr_q;
  logic [1:0]  bank_q;
  logic [2:0]  size_q;
  logic [3:0]  cs_n;
  logic [3:0]  lane_en;
  logic        bad_xfer;

  always #5 clk = ~clk;

  mux_addr_latch dut_i (
    .clk(clk), .rst(rst), .strobe_n(strobe_n), .ad_in(ad_in), .ack(ack),
    .addr_q(addr_q), .bank_q(bank_q), .size_q(size_q),
    .cs_n(cs_n), .lane_en(lane_en), .bad_xfer(bad_xfer)
  );

  typedef struct packed {
    logic [24:0] a;
    logic [1:0]  b;
    logic [2:0]  s;
    logic [3:0]  cs;
    logic [3:0]  ln;
    logic        bad;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // bench model state
  exp_t m = '{a: '0, b: '0, s: '0, cs: 4'hF, ln: '0, bad: 1'b0};

  function automatic logic [4:0] ref_lane(input logic [2:0] sz, input logic [1:0] off);
    // returns {valid, lanes}
    case (sz)
      3'b001: case (off)
        2'd0: return {1'b1, 4'b1000};
        2'd1: return {1'b1, 4'b0100};
        2'd2: return {1'b1, 4'b0010};
        default: return {1'b1, 4'b0001};
      endcase
      3'b010: begin
        if (off == 2'd0) return {1'b1, 4'b1100};
        if (off == 2'd2) return {1'b1, 4'b0011};
        return 5'b0;
      end
      3'b100: return (off == 2'd0) ? {1'b1, 4'b1111} : 5'b0;
      default: return 5'b0;
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic b31, input logic [2:0] sz,
      input logic b27, input logic [1:0] bk, input logic [24:0] a);
    return {b31, sz, b27, bk, a};
  endfunction

  task automatic step(input logic r, input logic sn, input logic [31:0] ad,
                      input logic ak, input string tag);
    logic [4:0] vl;
    @(negedge clk);
    rst = r; strobe_n = sn; ad_in = ad; ack = ak;
    if (r) begin
      m = '{a: '0, b: '0, s: '0, cs: 4'hF, ln: '0, bad: 1'b0};
    end else if (!sn) begin
      m.a = ad[24:0]; m.b = ad[26:25]; m.s = ad[30:28];
      vl = ref_lane(ad[30:28], ad[1:0]);
      m.ln = vl[3:0];
      m.bad = !vl[4];
      m.cs = vl[4] ? ~(4'b0001 << ad[26:25]) : 4'hF;
    end else if (ak) begin
      m.cs = 4'hF; m.ln = '0; m.bad = 1'b0;
    end
    exp_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  // monitor: compares 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e, act;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = '{a: addr_q, b: bank_q, s: size_q, cs: cs_n, ln: lane_en, bad: bad_xfer};
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s actual a=%h b=%0d s=%b cs=%b ln=%b bad=%b expected a=%h b=%0d s=%b cs=%b ln=%b bad=%b",
            t, act.a, act.b, act.s, act.cs, act.ln, act.bad,
            e.a, e.b, e.s, e.cs, e.ln, e.bad);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(1, 1, '0, 0, "R1");
    step(1, 0, mk(0, 3'b100, 0, 2'd3, 25'h1ABCDE0), 1, "R1");
    // R2 capture and reload while strobe low
    step(0, 0, mk(0, 3'b100, 0, 2'd2, 25'h0123450), 0, "R2");
    step(0, 0, mk(0, 3'b001, 0, 2'd1, 25'h1FFFFF1), 0, "R2");
    // R3 hold with strobe high and bus changing
    step(0, 1, mk(0, 3'b010, 0, 2'd3, 25'h0000002), 0, "R3");
    step(0, 1, 32'hFFFF_FFFF, 0, "R3");
    // R11 acknowledge clears selects, fields kept
    step(0, 1, 32'h5555_5555, 1, "R11");
    step(0, 1, '0, 0, "R11");
    // R4 ignored bits 31 and 27
    step(0, 0, mk(1, 3'b010, 1, 2'd0, 25'h0ABC002), 0, "R4");
    step(0, 0, mk(1, 3'b001, 0, 2'd3, 25'h0000003), 0, "R4");
    step(0, 0, mk(0, 3'b001, 1, 2'd3, 25'h0000003), 0, "R4");
    // R5 each bank alone
    for (int b = 0; b < 4; b++)
      step(0, 0, mk(0, 3'b100, 0, 2'(b), 25'h0001000), 0, "R5");
    // R12 capture wins over simultaneous ack
    step(0, 0, mk(0, 3'b010, 0, 2'd1, 25'h0000010), 1, "R12");
    // full sweep
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 8; s++)
        for (int o = 0; o < 4; o++) begin
          string tg;
          if (s == 1) tg = "R6";
          else if (s == 2) tg = (o == 0 || o == 2) ? "R7" : "R10";
          else if (s == 4) tg = (o == 0) ? "R8" : "R10";
          else tg = "R9";
          step(0, 0, mk(o[0], 3'(s), b[0], 2'(b), 25'(o + 4 * (b + 7 * s))), 0, tg);
        end
    // invalid flag cleared by ack (R11), then reset mid-cycle (R1)
    step(0, 0, mk(0, 3'b111, 0, 2'd2, 25'h0000000), 0, "R9");
    step(0, 1, '0, 1, "R11");
    step(0, 0, mk(0, 3'b001, 0, 2'd2, 25'h0000002), 0, "R6");
    step(1, 1, '0, 0, "R1");
    step(0, 1, '0, 0, "R1");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule